// File: doc/BRIEF.md
# Fly-by DMA Handshake Controller

This block moves bytes from a peripheral straight into memory without the processor touching the data. A peripheral raises its request line. If the channel is not masked and bytes remain to be moved, the controller asks the processor for the system bus. It waits until the processor grants the bus. It then drives the memory address, acknowledges the peripheral, and pulses the I/O-read and memory-write strobes together, so that the byte passes from the device to memory in a single bus cycle.

Software loads a start address and a byte count while the controller is idle. After each byte the address steps up by one and the count steps down by one. When the count is used up, the controller gives the bus back and emits a one-clock terminal-count pulse. If the peripheral withdraws its request between bytes, the bus is released early and the remaining address and count are kept for the next request.

Top module: `dma_hs_ctrl`

## Requirements
- R1: After reset, bus_req, bus_oe, dev_ack, io_rd_stb, mem_wr_stb and tc_pulse are all low.
- R2: While chan_mask is high, dev_req is ignored and bus_req stays low.
- R3: With chan_mask low and a nonzero remaining count, a high dev_req sampled at a clock edge makes bus_req high after that edge.
- R4: While bus_req is high and bus_grant has not been seen, bus_oe, dev_ack and both strobes stay low.
- R5: For each byte, io_rd_stb and mem_wr_stb are high together with dev_ack and bus_oe for exactly STROBE_CYC clocks (2 by default).
- R6: During byte k of a run, mem_addr equals the start address plus k, modulo 2^ADDR_W, and it holds steady while the strobes are high.
- R7: After the last counted byte, bus_req and bus_oe fall, and tc_pulse is high for exactly one clock, in the same cycle that bus_req is first low.
- R8: If dev_req is low when a byte finishes and bytes remain, bus_req and bus_oe fall with no tc_pulse. A later request resumes at the next address with the remaining count.
- R9: cfg_load is acted on only while bus_req is low. A load while a request is in progress leaves the address and count unchanged.
- R10: With a loaded count of zero, dev_req raises no bus_req.
- R11: bus_oe is high only while bus_req is high, and it rises only after bus_grant has been high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load start address and byte count (accepted when idle) |
| cfg_addr | input | ADDR_W | Start memory address to load |
| cfg_cnt | input | CNT_W | Number of bytes to move |
| chan_mask | input | 1 | High blocks peripheral requests |
| dev_req | input | 1 | Peripheral transfer request |
| bus_grant | input | 1 | Processor grants the system bus |
| bus_req | output | 1 | Request for the system bus to the processor |
| bus_oe | output | 1 | Enable for the address and strobe drivers |
| dev_ack | output | 1 | Acknowledge to the peripheral during a byte |
| io_rd_stb | output | 1 | I/O read strobe |
| mem_wr_stb | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address of the current byte |
| tc_pulse | output | 1 | One-clock pulse when the count is used up |

## Verification
The hardest case to reach from the ports is a request that drops exactly between two bytes. There is only one clock, after a strobe falls and before the next byte begins, in which dev_req is sampled to decide whether to keep the bus. The stimulus watches for the falling edge of the write strobe and lowers dev_req in that same half-cycle. It then checks that the bus is released with no terminal pulse. A new request must resume at the following address and must deliver exactly the remaining bytes. A configuration load issued while the bus grant is being withheld checks that the load is ignored. A start address near the top of the address space checks the wrap.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

   // Controller sequencing states
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // no bus ownership, waiting for a usable request
      ST_REQ  = 2'd1,   // bus requested, waiting for grant
      ST_XFER = 2'd2,   // strobes active for one byte
      ST_NEXT = 2'd3    // address/count update, decide continue or release
   } dma_st_e;

endpackage

// File: rtl/dma_hs_regs.sv
module dma_hs_regs #(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              cnt_zero,
   output logic              cnt_last
);

   localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
         cnt  <= '0;
      end else if (load_en) begin
         addr <= load_addr;
         cnt  <= load_cnt;
      end else if (step) begin
         addr <= addr + ADDR_INC;   // wraps modulo 2^ADDR_W
         cnt  <= cnt - CNT_ONE;
      end
   end

   assign cnt_zero = (cnt == '0);
   assign cnt_last = (cnt == CNT_ONE);

endmodule

// File: rtl/dma_hs_fsm.sv
module dma_hs_fsm
   import dma_hs_pkg::*;
#(
   parameter int STROBE_CYC = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_ok,
   input  logic    bus_grant,
   input  logic    cnt_last,
   output dma_st_e state,
   output logic    tc
);

   localparam int TMR_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

   dma_st_e state_d;
   logic    tc_d;
   logic    strobe_done;

   // Strobe width timer: generate picks the variant for the parameter
   generate
      if (STROBE_CYC == 1) begin : g_no_tmr
         assign strobe_done = 1'b1;
      end else begin : g_tmr
         localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(STROBE_CYC - 1);
         logic [TMR_W-1:0] tmr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tmr <= '0;
            else if (state == ST_XFER && !strobe_done)
               tmr <= tmr + TMR_W'(1);
            else
               tmr <= '0;
         end
         assign strobe_done = (tmr == TMR_LAST);
      end
   endgenerate

   always_comb begin
      state_d = state;
      tc_d    = 1'b0;
      unique case (state)
         ST_IDLE: if (req_ok) state_d = ST_REQ;
         ST_REQ: begin
            if (!req_ok)        state_d = ST_IDLE;
            else if (bus_grant) state_d = ST_XFER;
         end
         ST_XFER: if (strobe_done) state_d = ST_NEXT;
         ST_NEXT: begin
            if (cnt_last) begin
               state_d = ST_IDLE;
               tc_d    = 1'b1;
            end else if (req_ok) begin
               state_d = ST_XFER;
            end else begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         tc    <= 1'b0;
      end else begin
         state <= state_d;
         tc    <= tc_d;
      end
   end

endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
   import dma_hs_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int CNT_W      = 16,
   parameter int STROBE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CNT_W-1:0]  cfg_cnt,
   input  logic              chan_mask,
   input  logic              dev_req,
   input  logic              bus_grant,
   output logic              bus_req,
   output logic              bus_oe,
   output logic              dev_ack,
   output logic              io_rd_stb,
   output logic              mem_wr_stb,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              tc_pulse
);

   initial begin
      if (ADDR_W < 1 || ADDR_W > 64) $fatal(1, "ADDR_W out of range");
      if (CNT_W < 1 || CNT_W > 32)   $fatal(1, "CNT_W out of range");
      if (STROBE_CYC < 1 || STROBE_CYC > 256) $fatal(1, "STROBE_CYC out of range");
   end

   dma_st_e state;
   logic    cnt_zero, cnt_last, req_ok, tc;

   assign req_ok = dev_req && !chan_mask && !cnt_zero;

   dma_hs_fsm #(.STROBE_CYC(STROBE_CYC)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_ok    (req_ok),
      .bus_grant (bus_grant),
      .cnt_last  (cnt_last),
      .state     (state),
      .tc        (tc)
   );

   dma_hs_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (cfg_load && state == ST_IDLE),
      .load_addr (cfg_addr),
      .load_cnt  (cfg_cnt),
      .step      (state == ST_NEXT),
      .addr      (mem_addr),
      .cnt_zero  (cnt_zero),
      .cnt_last  (cnt_last)
   );

   assign bus_req    = (state != ST_IDLE);
   assign bus_oe     = (state == ST_XFER) || (state == ST_NEXT);
   assign dev_ack    = (state == ST_XFER);
   assign io_rd_stb  = (state == ST_XFER);
   assign mem_wr_stb = (state == ST_XFER);
   assign tc_pulse   = tc;

endmodule

// File: rtl/dma_hs_chk.sv
module dma_hs_chk #(
   parameter int ADDR_W     = 20,
   parameter int STROBE_CYC = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chan_mask,
   input logic              bus_grant,
   input logic              bus_req,
   input logic              bus_oe,
   input logic              mem_wr_stb,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              tc_pulse
);

   logic [15:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_len <= '0;
      else if (mem_wr_stb) run_len <= run_len + 16'd1;
      else                 run_len <= '0;
   end

   assert_oe_inside_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> bus_req);

   assert_oe_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> $past(bus_grant));

   assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req && chan_mask) |=> !bus_req);

   assert_strobe_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_stb |-> (run_len < 16'(STROBE_CYC)));

   assert_strobe_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wr_stb && run_len != 16'd0) |-> (run_len == 16'(STROBE_CYC)));

   assert_addr_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_stb && $past(mem_wr_stb)) |-> $stable(mem_addr));

   assert_tc_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tc_pulse |=> !tc_pulse);

   assert_tc_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tc_pulse |-> !bus_req);

endmodule

bind dma_hs_ctrl dma_hs_chk #(.ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chan_mask  (chan_mask),
   .bus_grant  (bus_grant),
   .bus_req    (bus_req),
   .bus_oe     (bus_oe),
   .mem_wr_stb (mem_wr_stb),
   .mem_addr   (mem_addr),
   .tc_pulse   (tc_pulse)
);

// File: tb/tb_dma_hs_ctrl.sv
`timescale 1ns/1ps
module tb_dma_hs_ctrl;

   localparam int AW = 20;
   localparam int CW = 16;
   localparam int SC = 2;
   localparam int NV = 4;

   localparam logic [AW-1:0] V_ADDR [NV] = '{20'h00010, 20'h12340, 20'hFFFFE, 20'h0ABCD};
   localparam int            V_CNT  [NV] = '{1, 3, 4, 6};

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_load = 1'b0, chan_mask = 1'b0, dev_req = 1'b0, bus_grant = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [CW-1:0] cfg_cnt = '0;
   logic bus_req, bus_oe, dev_ack, io_rd_stb, mem_wr_stb, tc_pulse;
   logic [AW-1:0] mem_addr;

   int errors = 0, checks = 0, cycles = 0;

   always #2.5 clk = ~clk;

   dma_hs_ctrl #(.ADDR_W(AW), .CNT_W(CW), .STROBE_CYC(SC)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
      .cfg_cnt(cfg_cnt), .chan_mask(chan_mask), .dev_req(dev_req),
      .bus_grant(bus_grant), .bus_req(bus_req), .bus_oe(bus_oe),
      .dev_ack(dev_ack), .io_rd_stb(io_rd_stb), .mem_wr_stb(mem_wr_stb),
      .mem_addr(mem_addr), .tc_pulse(tc_pulse)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++; checks++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic load(input logic [AW-1:0] a, input logic [CW-1:0] n);
      @(negedge clk);
      cfg_load = 1'b1; cfg_addr = a; cfg_cnt = n;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   // Runs a request with grant following bus_req; stop_after>0 drops the request after that many bytes
   task automatic run_xfer(input logic [AW-1:0] a0, input int n, input int stop_after);
      int idx = 0, run = 0, guard = 0;
      bit tc_seen = 0, stopped = 0;
      dev_req = 1'b1;
      while (!tc_seen && !stopped && guard < 2000) begin
         @(negedge clk);
         guard++;
         if (mem_wr_stb) begin
            run++;
            check(io_rd_stb && dev_ack && bus_oe, "R5 strobes/ack together",
                  {io_rd_stb, dev_ack, bus_oe}, 3'b111);
            check(mem_addr == AW'(a0 + AW'(idx)), "R6 byte address", mem_addr, AW'(a0 + AW'(idx)));
         end else if (run != 0) begin
            check(run == SC, "R5 strobe width", run, SC);
            idx++; run = 0;
            if (stop_after > 0 && idx == stop_after) begin
               dev_req = 1'b0; stopped = 1;
            end
         end
         if (tc_pulse) begin
            tc_seen = 1;
            check(!bus_req && !bus_oe, "R7 bus released at tc", {bus_req, bus_oe}, 0);
            check(idx == n, "R7 byte count at tc", idx, n);
         end
         bus_grant = bus_req;
      end
      if (stopped) begin
         @(negedge clk);
         check(!bus_req && !bus_oe, "R8 release on drop", {bus_req, bus_oe}, 0);
         check(!tc_pulse, "R8 no tc on drop", tc_pulse, 0);
         bus_grant = 1'b0;
      end else begin
         check(tc_seen, "R7 tc seen", tc_seen, 1);
         dev_req = 1'b0;
         @(negedge clk);
         check(!tc_pulse, "R7 tc one clock", tc_pulse, 0);
         bus_grant = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check({bus_req, bus_oe, dev_ack, io_rd_stb, mem_wr_stb, tc_pulse} == 6'b0,
            "R1 reset outputs", {bus_req, bus_oe, dev_ack, io_rd_stb, mem_wr_stb, tc_pulse}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({bus_req, bus_oe, tc_pulse} == 3'b0, "R1 after release", {bus_req, bus_oe, tc_pulse}, 0);

      // Vector table walk (includes address wrap in vector 2, R6)
      for (int v = 0; v < NV; v++) begin
         load(V_ADDR[v], CW'(V_CNT[v]));
         run_xfer(V_ADDR[v], V_CNT[v], 0);
      end

      // R2: masked request ignored, then same setup runs once unmasked
      load(20'h04000, 16'd3);
      chan_mask = 1'b1; dev_req = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check(!bus_req, "R2 mask blocks request", bus_req, 0);
      end
      dev_req = 1'b0; chan_mask = 1'b0;
      run_xfer(20'h04000, 3, 0);

      // R10: zero count raises no bus request
      load(20'h00500, 16'd0);
      dev_req = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(!bus_req, "R10 zero count", bus_req, 0);
      end
      dev_req = 1'b0;

      // R3, R4, R9: request without grant; load during request is ignored
      load(20'h00200, 16'd2);
      dev_req = 1'b1;
      @(negedge clk);
      check(bus_req, "R3 bus_req after request", bus_req, 1);
      for (int i = 0; i < 4; i++) begin
         if (i == 1) begin cfg_load = 1'b1; cfg_addr = 20'h55555; cfg_cnt = 16'd9; end
         else cfg_load = 1'b0;
         @(negedge clk);
         check({bus_oe, dev_ack, io_rd_stb, mem_wr_stb} == 4'b0, "R4 nothing before grant",
               {bus_oe, dev_ack, io_rd_stb, mem_wr_stb}, 0);
      end
      cfg_load = 1'b0;
      run_xfer(20'h00200, 2, 0);   // R9: original address and count used

      // R8: drop between bytes, then resume
      load(20'h00100, 16'd5);
      run_xfer(20'h00100, 5, 1);
      repeat (2) @(negedge clk);
      run_xfer(20'h00101, 4, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule